// File: doc/BRIEF.md
# Serial Transmitter with Flow Control

This block turns queued characters into an asynchronous serial stream on `txd`. The stream is timed by a single-cycle enable, `tick16`, that pulses sixteen times per bit. The host writes characters into an eight-entry queue. The block sends each one LSB first, framed by a low start bit, an optional parity bit and a stop interval whose length is set in sixteenths of a bit. The character length is 5, 6, 7 or 8 bits.

Two optional handshakes pace the line. With clear-to-send pacing on, the active-low `ctsn` input is examined only when a character is about to begin. With request-to-send auto release on, the active-low `rtsn` output is raised one bit time after the last stop interval has ended. Command pulses force a break (a continuous low level) and end it. They also assert and negate `rtsn` by hand. `tx_rdy` and `tx_emt` report the state of the queue and the line.

Top module: `sertx_flow`

## Requirements
- R1: A frame is a start bit at 0 for 16 ticks, then the character bits LSB first for 16 ticks each. `char_len` 0, 1, 2 and 3 selects 5, 6, 7 and 8 bits. Between frames `txd` is 1.
- R2: With `par_en` = 1, one parity bit of 16 ticks follows the data. `par_odd` = 0 gives an even count of ones over data plus parity, and `par_odd` = 1 gives an odd count.
- R3: The stop interval lasts 17 + `stop_code`[2:0] ticks when `stop_code`[3] = 1. It lasts the same when `char_len` = 0. In every other case it lasts 9 + `stop_code`[2:0] ticks.
- R4: When another character is queued and allowed to start, its start bit follows the previous stop interval with no extra idle time.
- R5: With `cts_flow_en` = 1 and `ctsn` = 1, no character starts and `txd` stays 1. With `cts_flow_en` = 0, `ctsn` has no effect.
- R6: A change of `ctsn` after a character has started does not alter that character.
- R7: The queue holds 8 characters. `tx_rdy` is 1 exactly when it is not full, and a write while full is dropped. `tx_emt` is 1 when the queue is empty and no frame or break is on the line.
- R8: With `tx_en` = 0, writes are dropped. Characters already queued are still sent.
- R9: After reset `rtsn` = 1. A `rts_assert` pulse drives it to 0 and a `rts_negate` pulse drives it to 1.
- R10: With `rts_auto_en` = 1, `rtsn` returns to 1 exactly 16 ticks after the line drains (the tick edge that ends the stop interval counts as 0). This happens only if at least one character was sent since `rtsn` was asserted. With `rts_auto_en` = 0 it stays 0.
- R11: A `brk_start` pulse is taken only while `tx_en` = 1. The break waits until every queued and in-flight character is sent, then holds `txd` at 0 within two bit times.
- R12: After `brk_stop`, `txd` returns to 1 within two bit times. It then stays 1 for at least 16 ticks before the next start bit.
- R13: `txd` changes only on clock edges where `tick16` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick16 | input | 1 | One-cycle enable, 16 per bit |
| tx_en | input | 1 | Accept writes and break requests |
| char_len | input | 2 | Character length code (5 + value bits) |
| par_en | input | 1 | Append a parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| stop_code | input | 4 | Stop interval length code |
| cts_flow_en | input | 1 | Gate character starts with `ctsn` |
| rts_auto_en | input | 1 | Release `rtsn` automatically after drain |
| ctsn | input | 1 | Clear to send, active low |
| wr_valid | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 8 | Character to queue |
| brk_start | input | 1 | Command pulse: begin break |
| brk_stop | input | 1 | Command pulse: end break |
| rts_assert | input | 1 | Command pulse: drive `rtsn` low |
| rts_negate | input | 1 | Command pulse: drive `rtsn` high |
| txd | output | 1 | Serial output |
| rtsn | output | 1 | Request to send, active low |
| tx_rdy | output | 1 | Queue can take a character |
| tx_emt | output | 1 | Queue and line are both idle |

## Verification
The embedded properties assume three things about the inputs. First, `tick16` is a single-cycle pulse. Second, each command input is a one-cycle pulse and no two commands arrive together. Third, the format inputs (`char_len`, parity, `stop_code`) do not change while a frame is on the line. The stimulus respects all three. It produces `tick16` on every second clock and issues commands through a task that raises one strobe for exactly one cycle. It changes the format only after `tx_emt` has been seen high, and it toggles `ctsn` mid-frame only to exercise the rule that a started character is not disturbed.

// File: rtl/stx_pkg.sv
// stx_pkg: shared constants, the frame sequencer state type and the
// stop-interval length function for the serial transmitter.
// Assumes a 16x oversampling enable, so stop lengths are counted in ticks.
package stx_pkg;
    localparam int TICKS_PER_BIT = 16;
    localparam int CHAR_W        = 8;
    localparam int TCNT_W        = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BRK,
        ST_GAP
    } stx_state_e;

    // Stop interval in ticks: long range when the code MSB is set or the
    // character is 5 bits wide, short range otherwise.
    function automatic logic [TCNT_W-1:0] stop_ticks(input logic [3:0] code,
                                                     input logic       five_bit);
        logic [TCNT_W-1:0] base;
        base = (code[3] || five_bit) ? TCNT_W'(17) : TCNT_W'(9);
        return base + TCNT_W'(code[2:0]);
    endfunction
endpackage

// File: rtl/stx_fifo.sv
// stx_fifo: first-in first-out character queue.
// Assumes the caller never pushes while full nor pops while empty;
// the head entry is presented combinationally on dout.
module stx_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign dout  = mem[rd_ptr];

    // Store the pushed character at the write pointer.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    // Advance pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);
endmodule

// File: rtl/stx_frame.sv
// stx_frame: serial frame sequencer. Builds start, data, parity and stop
// intervals from the queue head, gates starts with clear-to-send, and runs
// the break / post-break marking sequence.
// Assumes format inputs are steady while a frame is on the line.
module stx_frame
    import stx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [1:0]        char_len,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [3:0]        stop_code,
    input  logic              cts_flow_en,
    input  logic              ctsn,
    input  logic              fifo_empty,
    input  logic [CHAR_W-1:0] fifo_dout,
    input  logic              brk_start,
    input  logic              brk_stop,
    output logic              pop,
    output logic              busy,
    output logic              txd
);
    localparam logic [TCNT_W-1:0] BIT_LAST = TCNT_W'(TICKS_PER_BIT - 1);

    stx_state_e        state;
    logic [TCNT_W-1:0] cnt;
    logic [2:0]        bidx;
    logic [CHAR_W-1:0] shreg;
    logic              par_bit;
    logic              brk_pend;
    logic              brk_end;

    logic [TCNT_W-1:0] stop_last;
    logic [2:0]        last_bit;
    logic [CHAR_W-1:0] mask;
    logic              can_start;
    logic              launch;

    assign stop_last = stop_ticks(stop_code, char_len == 2'd0) - TCNT_W'(1);
    assign last_bit  = 3'd4 + {1'b0, char_len};
    assign mask      = 8'hFF >> (2'd3 - char_len);
    assign can_start = !fifo_empty && (!cts_flow_en || !ctsn);

    // A character may begin from idle, right after a stop interval, or
    // right after the post-break marking interval.
    assign launch = tick && can_start &&
                    ((state == ST_IDLE) ||
                     (state == ST_STOP && cnt == stop_last) ||
                     (state == ST_GAP  && cnt == BIT_LAST));
    assign pop  = launch;
    assign busy = (state != ST_IDLE);

    // Drive the line level from the current interval.
    always_comb begin
        case (state)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = shreg[0];
            ST_PAR:   txd = par_bit;
            ST_BRK:   txd = 1'b0;
            default:  txd = 1'b1;
        endcase
    end

    // Sequence intervals on tick edges and latch break commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            bidx     <= '0;
            shreg    <= '0;
            par_bit  <= 1'b0;
            brk_pend <= 1'b0;
            brk_end  <= 1'b0;
        end else begin
            if (brk_stop)       brk_pend <= 1'b0;
            else if (brk_start) brk_pend <= 1'b1;
            if (brk_stop && state == ST_BRK) brk_end <= 1'b1;

            if (launch) begin
                state   <= ST_START;
                cnt     <= '0;
                bidx    <= '0;
                shreg   <= fifo_dout;
                par_bit <= ^(fifo_dout & mask) ^ par_odd;
            end else if (tick) begin
                case (state)
                    ST_IDLE: begin
                        if (brk_pend && fifo_empty) begin
                            state    <= ST_BRK;
                            brk_pend <= 1'b0;
                            brk_end  <= 1'b0;
                        end
                    end
                    ST_START: begin
                        if (cnt == BIT_LAST) begin
                            state <= ST_DATA;
                            cnt   <= '0;
                        end else cnt <= cnt + TCNT_W'(1);
                    end
                    ST_DATA: begin
                        if (cnt == BIT_LAST) begin
                            cnt <= '0;
                            if (bidx == last_bit) begin
                                state <= par_en ? ST_PAR : ST_STOP;
                            end else begin
                                bidx  <= bidx + 3'd1;
                                shreg <= shreg >> 1;
                            end
                        end else cnt <= cnt + TCNT_W'(1);
                    end
                    ST_PAR: begin
                        if (cnt == BIT_LAST) begin
                            state <= ST_STOP;
                            cnt   <= '0;
                        end else cnt <= cnt + TCNT_W'(1);
                    end
                    ST_STOP: begin
                        if (cnt == stop_last) state <= ST_IDLE;
                        else cnt <= cnt + TCNT_W'(1);
                    end
                    ST_BRK: begin
                        if (brk_end) begin
                            state   <= ST_GAP;
                            cnt     <= '0;
                            brk_end <= 1'b0;
                        end
                    end
                    ST_GAP: begin
                        if (cnt == BIT_LAST) state <= ST_IDLE;
                        else cnt <= cnt + TCNT_W'(1);
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R5
    cts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_flow_en && ctsn && state != ST_START) |=> (state != ST_START));

    // R11
    brk_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_BRK) |-> $past(fifo_empty));

    // R13
    txd_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(txd));

    // R12
    gap_after_brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(state == ST_BRK) |-> (state == ST_GAP));
endmodule

// File: rtl/stx_rts.sv
// stx_rts: request-to-send output. Manual assert/negate commands, plus an
// optional release one bit time after the transmitter drains.
// Assumes command pulses are single-cycle and tx_emt comes from the
// queue and sequencer.
module stx_rts
    import stx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic tx_emt,
    input  logic auto_en,
    input  logic cmd_on,
    input  logic cmd_off,
    output logic rtsn
);
    localparam int IW = $clog2(TICKS_PER_BIT);
    localparam logic [IW-1:0] IDLE_LAST = IW'(TICKS_PER_BIT - 1);

    logic          armed;
    logic [IW-1:0] icnt;

    // Track manual commands, arm on activity, release after an idle bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rtsn  <= 1'b1;
            armed <= 1'b0;
            icnt  <= '0;
        end else if (cmd_off) begin
            rtsn  <= 1'b1;
            armed <= 1'b0;
        end else if (cmd_on) begin
            rtsn  <= 1'b0;
            armed <= 1'b0;
        end else if (!tx_emt) begin
            armed <= ~rtsn;
            icnt  <= '0;
        end else if (tick) begin
            if (armed && auto_en && icnt == IDLE_LAST) begin
                rtsn  <= 1'b1;
                armed <= 1'b0;
            end else if (icnt != IDLE_LAST) begin
                icnt <= icnt + IW'(1);
            end
        end
    end

    // R9 R10
    rts_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rtsn) |-> ($past(cmd_off) || $past(auto_en && tx_emt && tick)));

    // R9
    rts_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_on && !cmd_off) |=> !rtsn);
endmodule

// File: rtl/sertx_flow.sv
// sertx_flow: single-channel asynchronous transmitter with character queue,
// clear-to-send pacing, request-to-send auto release and break control.
// Assumes tick16 is a one-cycle enable at 16x the bit rate.
module sertx_flow
    import stx_pkg::*;
#(
    parameter int FIFO_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick16,
    input  logic        tx_en,
    input  logic [1:0]  char_len,
    input  logic        par_en,
    input  logic        par_odd,
    input  logic [3:0]  stop_code,
    input  logic        cts_flow_en,
    input  logic        rts_auto_en,
    input  logic        ctsn,
    input  logic        wr_valid,
    input  logic [7:0]  wr_data,
    input  logic        brk_start,
    input  logic        brk_stop,
    input  logic        rts_assert,
    input  logic        rts_negate,
    output logic        txd,
    output logic        rtsn,
    output logic        tx_rdy,
    output logic        tx_emt
);
    logic              push, pop, f_empty, f_full, busy;
    logic [CHAR_W-1:0] head;

    assign push   = wr_valid && tx_en && !f_full;
    assign tx_rdy = !f_full;
    assign tx_emt = f_empty && !busy;

    stx_fifo #(.DEPTH(FIFO_DEPTH), .W(CHAR_W)) i_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .din(wr_data),
        .pop(pop), .dout(head), .empty(f_empty), .full(f_full)
    );

    stx_frame i_frame (
        .clk(clk), .rst_n(rst_n), .tick(tick16),
        .char_len(char_len), .par_en(par_en), .par_odd(par_odd),
        .stop_code(stop_code), .cts_flow_en(cts_flow_en), .ctsn(ctsn),
        .fifo_empty(f_empty), .fifo_dout(head),
        .brk_start(brk_start && tx_en), .brk_stop(brk_stop),
        .pop(pop), .busy(busy), .txd(txd)
    );

    stx_rts i_rts (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .tx_emt(tx_emt),
        .auto_en(rts_auto_en), .cmd_on(rts_assert), .cmd_off(rts_negate),
        .rtsn(rtsn)
    );

    // R8
    no_write_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !pop) |=> ($past(f_empty) == f_empty));
endmodule

// File: tb/test_sertx_flow.sv
module test_sertx_flow;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n, tick16, tx_en, par_en, par_odd, cts_flow_en, rts_auto_en, ctsn;
    logic [1:0] char_len;
    logic [3:0] stop_code;
    logic       wr_valid, brk_start, brk_stop, rts_assert, rts_negate;
    logic [7:0] wr_data;
    logic       txd, rtsn, tx_rdy, tx_emt;

    sertx_flow i_sertx_flow (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .tx_en(tx_en),
        .char_len(char_len), .par_en(par_en), .par_odd(par_odd),
        .stop_code(stop_code), .cts_flow_en(cts_flow_en), .rts_auto_en(rts_auto_en),
        .ctsn(ctsn), .wr_valid(wr_valid), .wr_data(wr_data),
        .brk_start(brk_start), .brk_stop(brk_stop), .rts_assert(rts_assert),
        .rts_negate(rts_negate), .txd(txd), .rtsn(rtsn), .tx_rdy(tx_rdy), .tx_emt(tx_emt)
    );

    typedef struct packed {
        logic [1:0] len;
        logic       pen;
        logic       podd;
        logic [3:0] code;
        logic [7:0] data;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd3, 1'b0, 1'b0, 4'd0,  8'hA5},
        '{2'd3, 1'b1, 1'b0, 4'd7,  8'h3C},
        '{2'd2, 1'b1, 1'b1, 4'd8,  8'h55},
        '{2'd1, 1'b0, 1'b0, 4'd15, 8'h2B},
        '{2'd0, 1'b0, 1'b0, 4'd0,  8'h13},
        '{2'd0, 1'b1, 1'b1, 4'd7,  8'h1F},
        '{2'd0, 1'b0, 1'b0, 4'd12, 8'h0A},
        '{2'd2, 1'b1, 1'b0, 4'd3,  8'h7E}
    };

    int checks = 0;
    int errors = 0;

    // Tick-edge log of the line and rtsn.
    logic ltx  [0:4095];
    logic lrts [0:4095];
    int   lidx = 0;
    logic tick_q = 1'b0;
    logic tphase = 1'b0;

    always @(posedge clk) tick_q <= tick16;
    always @(negedge clk) begin
        if (tick_q && lidx < 4096) begin
            ltx[lidx]  = txd;
            lrts[lidx] = rtsn;
            lidx++;
        end
    end

    initial begin
        tick16 = 1'b0;
        forever begin
            @(negedge clk);
            tphase = ~tphase;
            tick16 = tphase;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (2 * n) @(posedge clk);
        #1;
    endtask

    task automatic clr_log;
        @(posedge clk); #1;
        lidx = 0;
    endtask

    task automatic wr(input logic [7:0] d);
        @(posedge clk); #1;
        wr_valid = 1'b1; wr_data = d;
        @(posedge clk); #1;
        wr_valid = 1'b0;
    endtask

    task automatic cmd(input int k);
        @(posedge clk); #1;
        case (k)
            0: brk_start  = 1'b1;
            1: brk_stop   = 1'b1;
            2: rts_assert = 1'b1;
            default: rts_negate = 1'b1;
        endcase
        @(posedge clk); #1;
        brk_start = 1'b0; brk_stop = 1'b0; rts_assert = 1'b0; rts_negate = 1'b0;
    endtask

    task automatic wait_emt;
        int g;
        g = 0;
        while (!tx_emt && g < 20000) begin
            @(posedge clk); #1;
            g++;
        end
    endtask

    function automatic logic sm(input int i);
        return (i >= 0 && i < lidx) ? ltx[i] : 1'b1;
    endfunction

    function automatic int find_fall(input int from);
        for (int i = from; i < lidx; i++)
            if (ltx[i] == 1'b0 && (i == 0 || ltx[i-1] == 1'b1)) return i;
        return -1;
    endfunction

    function automatic logic [7:0] get_char(input int f, input int n);
        logic [7:0] v;
        v = 8'h00;
        for (int i = 0; i < n; i++) v[i] = sm(f + 16 * (1 + i) + 8);
        return v;
    endfunction

    function automatic int exp_stop(input logic [1:0] len, input logic [3:0] code);
        if (code >= 4'd8)   return 17 + int'(code) - 8;
        if (len == 2'd0)    return 17 + int'(code);
        return 9 + int'(code);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        vec_t       t;
        int         n, p, f1, f2, s, len_l, cnt, r;
        logic [7:0] m, last;

        rst_n = 1'b0; tx_en = 1'b1; char_len = 2'd3; par_en = 1'b0; par_odd = 1'b0;
        stop_code = 4'd0; cts_flow_en = 1'b0; rts_auto_en = 1'b0; ctsn = 1'b1;
        wr_valid = 1'b0; wr_data = 8'h00; brk_start = 1'b0; brk_stop = 1'b0;
        rts_assert = 1'b0; rts_negate = 1'b0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // Reset state: R1 line idle, R7 status, R9 rtsn
        chk(txd == 1'b1, "R1 reset txd", txd, 1);
        chk(tx_rdy == 1'b1 && tx_emt == 1'b1, "R7 reset status", {tx_rdy, tx_emt}, 3);
        chk(rtsn == 1'b1, "R9 reset rtsn", rtsn, 1);

        // Format table; ctsn held high with pacing off also exercises R5.
        for (int v = 0; v < 8; v++) begin
            t = VECS[v];
            char_len = t.len; par_en = t.pen; par_odd = t.podd; stop_code = t.code;
            wait_ticks(1);
            clr_log;
            wr(t.data);
            wr(~t.data);
            wait_emt;
            wait_ticks(4);
            n = 5 + int'(t.len);
            p = t.pen ? 1 : 0;
            m = 8'hFF >> (3 - int'(t.len));
            f1 = find_fall(0);
            chk(f1 >= 0 && sm(f1 + 8) == 1'b0 && get_char(f1, n) == (t.data & m),
                "R1 R5 data bits", get_char(f1, n), t.data & m);
            if (t.pen) begin
                chk(sm(f1 + 16 * (1 + n) + 8) == ((^(t.data & m)) ^ t.podd),
                    "R2 parity bit", sm(f1 + 16 * (1 + n) + 8), (^(t.data & m)) ^ t.podd);
            end
            s = f1 + 16 * (1 + n + p);
            f2 = find_fall(s);
            len_l = f2 - s;
            chk(f2 >= 0 && len_l == exp_stop(t.len, t.code), "R3 stop ticks", len_l,
                exp_stop(t.len, t.code));
            chk(get_char(f2, n) == ((~t.data) & m), "R4 back-to-back char",
                get_char(f2, n), (~t.data) & m);
        end

        char_len = 2'd3; par_en = 1'b0; stop_code = 4'd0;

        // R5 / R6: clear-to-send pacing
        cts_flow_en = 1'b1; ctsn = 1'b1;
        clr_log;
        wr(8'h96);
        wait_ticks(60);
        chk(find_fall(0) == -1 && tx_emt == 1'b0, "R5 held by ctsn", find_fall(0), -1);
        ctsn = 1'b0;
        wait_ticks(4);
        ctsn = 1'b1;
        wait_emt;
        wait_ticks(4);
        f1 = find_fall(0);
        chk(f1 >= 0 && get_char(f1, 8) == 8'h96, "R6 mid-frame ctsn", get_char(f1, 8), 8'h96);

        // R7: queue depth and full behaviour
        clr_log;
        for (int k = 0; k < 8; k++) begin
            wr(8'h10 + 8'(k));
            if (k == 6) chk(tx_rdy == 1'b1, "R7 ready at 7", tx_rdy, 1);
        end
        chk(tx_rdy == 1'b0, "R7 not ready when full", tx_rdy, 0);
        wr(8'h99);
        ctsn = 1'b0;
        wait_emt;
        wait_ticks(4);
        cnt = 0; last = 8'h00;
        f1 = find_fall(0);
        while (f1 >= 0 && cnt < 20) begin
            cnt++;
            last = get_char(f1, 8);
            f1 = find_fall(f1 + 144);
        end
        chk(cnt == 8, "R7 frames sent", cnt, 8);
        chk(last == 8'h17, "R7 last char", last, 8'h17);
        cts_flow_en = 1'b0; ctsn = 1'b1;

        // R8: disable drains the queue and drops writes
        clr_log;
        wr(8'h01); wr(8'h02); wr(8'h03);
        tx_en = 1'b0;
        wait_emt;
        wait_ticks(4);
        cnt = 0;
        f1 = find_fall(0);
        while (f1 >= 0 && cnt < 20) begin
            cnt++;
            f1 = find_fall(f1 + 144);
        end
        chk(cnt == 3, "R8 queued frames finish", cnt, 3);
        clr_log;
        wr(8'h55);
        wait_ticks(20);
        chk(tx_emt == 1'b1 && find_fall(0) == -1, "R8 write dropped", tx_emt, 1);
        tx_en = 1'b1;

        // R9 / R10: request-to-send
        cmd(2);
        chk(rtsn == 1'b0, "R9 assert command", rtsn, 0);
        rts_auto_en = 1'b1;
        clr_log;
        wr(8'h5A);
        wait_emt;
        wait_ticks(30);
        f1 = find_fall(0);
        chk(f1 >= 0 && lrts[f1 + 168] == 1'b0 && lrts[f1 + 169] == 1'b1,
            "R10 auto release timing", f1 >= 0 ? lrts[f1 + 169] : 0, 1);
        cmd(2);
        rts_auto_en = 1'b0;
        clr_log;
        wr(8'h5B);
        wait_emt;
        wait_ticks(40);
        chk(rtsn == 1'b0, "R10 no release when off", rtsn, 0);
        cmd(3);
        chk(rtsn == 1'b1, "R9 negate command", rtsn, 1);

        // R11: break start rules
        tx_en = 1'b0;
        cmd(0);
        wait_ticks(40);
        tx_en = 1'b1;
        wait_ticks(40);
        chk(txd == 1'b1, "R11 break ignored when disabled", txd, 1);
        clr_log;
        wr(8'hC3);
        wait_ticks(3);
        cmd(0);
        wait_ticks(200);
        f1 = find_fall(0);
        chk(f1 >= 0 && get_char(f1, 8) == 8'hC3 && sm(f1 + 152) == 1'b1,
            "R11 frame completes before break", get_char(f1, 8), 8'hC3);
        chk(f1 >= 0 && sm(f1 + 153 + 32) == 1'b0 && txd == 1'b0,
            "R11 break within two bits", sm(f1 + 185), 0);
        wr(8'h3A);
        wait_ticks(10);
        chk(txd == 1'b0 && tx_emt == 1'b0, "R11 break holds with queued char", txd, 0);

        // R12: break stop and marking gap
        clr_log;
        cmd(1);
        wait_emt;
        wait_ticks(4);
        r = -1;
        for (int i = 0; i < lidx; i++)
            if (r < 0 && ltx[i] == 1'b1) r = i;
        f2 = (r >= 0) ? find_fall(r) : -1;
        chk(r >= 0 && r <= 32, "R12 mark within two bits", r, 32);
        chk(f2 >= 0 && f2 - r >= 16, "R12 mark gap", f2 - r, 16);
        chk(f2 >= 0 && get_char(f2, 8) == 8'h3A, "R12 char after break",
            get_char(f2, 8), 8'h3A);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule